// File: doc/BRIEF.md
# Twin-Ratio Dual-Port RAM

This block is a true dual-port synchronous memory. Each port has its own clock, enable, write enable, address, data and parity lines, and both ports work on one shared bit store. Each port picks its word shape at run time through a 3-bit mode input. The shapes are 1, 2 or 4 data bits, 8 data bits with 1 parity bit, or 16 data bits with 2 parity bits. A word written through a wide port can be read back bit for bit through a narrow port on the other side, and the reverse also works.

Reads and writes are both registered. Output data appears after the clock edge that samples the enabled request. On a write, the port's output shows the newly written word. The store holds `DATA_BITS` data bits plus `DATA_BITS/8` parity bits. The default is 1024 data bits. Setting `DATA_BITS` to 16384 gives the full 18,432-bit array.

Top module: `twin_ratio_ram`

## Requirements
- R1: The store holds `DATA_BITS` data bits and `DATA_BITS/8` parity bits, shared by both ports. Stored contents survive reset.
- R2: Mode codes are: 0 = 1-bit word, 1 = 2-bit, 2 = 4-bit, 3 = 8 data + 1 parity, 4 = 16 data + 2 parity. Codes 5 to 7 behave as code 0.
- R3: In a mode of data width w, word N occupies data-space bits N*w to N*w+w-1, with lower addresses in lower-order bits. Address bits at or above log2(DATA_BITS/w) are ignored.
- R4: In mode 3, the parity bit of word N is parity-space bit N. In mode 4, parity bit k of word N is parity-space bit 2N+k.
- R5: When en is high at a rising clock edge, the port's outputs after that edge show the addressed word. When en is low, the outputs hold and no write happens, even if we is high.
- R6: When en and we are both high at an edge, the outputs after that edge show the data just written (write-first).
- R7: Data output bits at or above the port's width read zero. The parity outputs read zero in modes 0, 1 and 2. Mode 3 uses data bits 7:0 and parity bit 0.
- R8: Data written through either port in any mode can be read back through the other port in any mode.
- R9: Both ports may write in the same cycle. All bits written by only one of the ports are stored. Bits written by both ports in the same cycle are undefined.
- R10: A low rst_n clears dout and doutp of both ports to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable |
| mode_a | input | 3 | Port A word shape |
| addr_a | input | log2(DATA_BITS) | Port A word address |
| din_a | input | 16 | Port A write data |
| dinp_a | input | 2 | Port A write parity |
| dout_a | output | 16 | Port A read data |
| doutp_a | output | 2 | Port A read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable |
| mode_b | input | 3 | Port B word shape |
| addr_b | input | log2(DATA_BITS) | Port B word address |
| din_b | input | 16 | Port B write data |
| dinp_b | input | 2 | Port B write parity |
| dout_b | output | 16 | Port B read data |
| doutp_b | output | 2 | Port B read parity |

## Verification
The assertions check on every cycle that a disabled port holds its outputs, that a write returns the written word at the next edge, and that unused data and parity lines stay zero for the shape used. The bench scenarios show the things that depend on stored contents. These are the bit-level address and parity mapping across all shapes, readback across ports with different shapes, the effect of ignored upper address bits, and concurrent writes from both ports into one row.

// File: rtl/trr_pkg.sv
package trr_pkg;

    localparam int ROW_DATA = 16;
    localparam int ROW_PAR  = 2;
    localparam int ROW_W    = ROW_DATA + ROW_PAR;

    localparam logic [2:0] MODE_X1  = 3'd0;
    localparam logic [2:0] MODE_X2  = 3'd1;
    localparam logic [2:0] MODE_X4  = 3'd2;
    localparam logic [2:0] MODE_X9  = 3'd3;
    localparam logic [2:0] MODE_X18 = 3'd4;

    // log2 of the data width of a shape; unknown codes act as one bit
    function automatic logic [2:0] shift_of(input logic [2:0] mode);
        case (mode)
            MODE_X2:  return 3'd1;
            MODE_X4:  return 3'd2;
            MODE_X9:  return 3'd3;
            MODE_X18: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic [ROW_DATA-1:0] lane_mask(input logic [2:0] sh);
        case (sh)
            3'd0:    return 16'h0001;
            3'd1:    return 16'h0003;
            3'd2:    return 16'h000F;
            3'd3:    return 16'h00FF;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/trr_bank.sv
// One storage bank, written only from its own port clock. The logical
// contents of a row are the XOR of the same row in both banks.
module trr_bank #(
    parameter  int ROWS   = 64,
    localparam int ROW_AW = $clog2(ROWS)
) (
    input  logic                     clk,
    input  logic                     wr,
    input  logic [ROW_AW-1:0]        wrow,
    input  logic [trr_pkg::ROW_W-1:0] wval,
    input  logic [ROW_AW-1:0]        rrow0,
    input  logic [ROW_AW-1:0]        rrow1,
    output logic [trr_pkg::ROW_W-1:0] rval0,
    output logic [trr_pkg::ROW_W-1:0] rval1
);
    logic [trr_pkg::ROW_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (wr) begin
            mem_q[wrow] <= wval;
        end
    end

    assign rval0 = mem_q[rrow0];
    assign rval1 = mem_q[rrow1];

endmodule

// File: rtl/trr_port.sv
// Per-port shape decode, write merge and registered read.
module trr_port
    import trr_pkg::*;
#(
    parameter  int DATA_BITS = 1024,
    localparam int ADDR_W    = $clog2(DATA_BITS),
    localparam int ROW_AW    = ADDR_W - 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               we,
    input  logic [2:0]         mode,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        din,
    input  logic [1:0]         dinp,
    input  logic [ROW_W-1:0]   own_row,
    input  logic [ROW_W-1:0]   other_row,
    output logic [ROW_AW-1:0]  row_o,
    output logic               wr_o,
    output logic [ROW_W-1:0]   store_o,
    output logic [15:0]        dout,
    output logic [1:0]         doutp
);
    typedef struct packed {
        logic [15:0] data;
        logic [1:0]  par;
    } out_t;

    out_t              st_d, st_q;
    logic [2:0]        sh;
    logic [ADDR_W-1:0] off;
    logic [3:0]        col;
    logic [15:0]       dmask, dval;
    logic [1:0]        pmask, pval;
    logic [ROW_W-1:0]  logical, merged, src;

    always_comb begin
        sh    = shift_of(mode);
        off   = addr << sh;
        col   = off[3:0];
        dmask = lane_mask(sh) << col;
        dval  = (din & lane_mask(sh)) << col;
        pmask = 2'b00;
        pval  = 2'b00;
        if (sh == 3'd3) begin
            pmask = 2'b01 << off[3];
            pval  = {1'b0, dinp[0]} << off[3];
        end else if (sh == 3'd4) begin
            pmask = 2'b11;
            pval  = dinp;
        end
        logical = own_row ^ other_row;
        merged  = {(logical[17:16] & ~pmask) | pval,
                   (logical[15:0]  & ~dmask) | dval};
        src     = (en && we) ? merged : logical;

        st_d = st_q;
        if (en) begin
            st_d.data = (src[15:0] >> col) & lane_mask(sh);
            if (sh == 3'd3)      st_d.par = {1'b0, src[16 + off[3]]};
            else if (sh == 3'd4) st_d.par = src[17:16];
            else                 st_d.par = 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o   = off[ADDR_W-1:4];
    assign wr_o    = en && we;
    assign store_o = merged ^ other_row;
    assign dout    = st_q.data;
    assign doutp   = st_q.par;

    // R5: a disabled port keeps its outputs
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(doutp)));

    // R6: write-first returns the written data bits
    assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (dout == ($past(din) & lane_mask(shift_of($past(mode))))));

    // R7: data lines above the port width stay zero
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((dout & ~lane_mask(shift_of($past(mode)))) == 16'h0000));

    // R7: parity lines stay zero in shapes without parity
    assert_par_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (mode != MODE_X9) && (mode != MODE_X18)) |=> (doutp == 2'b00));

endmodule

// File: rtl/twin_ratio_ram.sv
module twin_ratio_ram
    import trr_pkg::*;
#(
    parameter  int DATA_BITS = 1024,
    localparam int ADDR_W    = $clog2(DATA_BITS),
    localparam int ROWS      = DATA_BITS / ROW_DATA,
    localparam int ROW_AW    = $clog2(ROWS)
) (
    input  logic              rst_n,
    input  logic              clk_a,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [2:0]        mode_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [15:0]       din_a,
    input  logic [1:0]        dinp_a,
    output logic [15:0]       dout_a,
    output logic [1:0]        doutp_a,
    input  logic              clk_b,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [2:0]        mode_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [15:0]       din_b,
    input  logic [1:0]        dinp_b,
    output logic [15:0]       dout_b,
    output logic [1:0]        doutp_b
);
    localparam int NPORT = 2;

    logic              clk_v   [NPORT];
    logic              en_v    [NPORT];
    logic              we_v    [NPORT];
    logic [2:0]        mode_v  [NPORT];
    logic [ADDR_W-1:0] addr_v  [NPORT];
    logic [15:0]       din_v   [NPORT];
    logic [1:0]        dinp_v  [NPORT];
    logic [15:0]       dout_v  [NPORT];
    logic [1:0]        doutp_v [NPORT];
    logic [ROW_AW-1:0] row_v   [NPORT];
    logic              wr_v    [NPORT];
    logic [ROW_W-1:0]  store_v [NPORT];
    logic [ROW_W-1:0]  rd_v    [NPORT][NPORT];

    assign clk_v  = '{clk_a,  clk_b};
    assign en_v   = '{en_a,   en_b};
    assign we_v   = '{we_a,   we_b};
    assign mode_v = '{mode_a, mode_b};
    assign addr_v = '{addr_a, addr_b};
    assign din_v  = '{din_a,  din_b};
    assign dinp_v = '{dinp_a, dinp_b};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        trr_bank #(.ROWS(ROWS)) u_bank (
            .clk   (clk_v[p]),
            .wr    (wr_v[p]),
            .wrow  (row_v[p]),
            .wval  (store_v[p]),
            .rrow0 (row_v[0]),
            .rrow1 (row_v[1]),
            .rval0 (rd_v[p][0]),
            .rval1 (rd_v[p][1])
        );

        trr_port #(.DATA_BITS(DATA_BITS)) u_port (
            .clk       (clk_v[p]),
            .rst_n     (rst_n),
            .en        (en_v[p]),
            .we        (we_v[p]),
            .mode      (mode_v[p]),
            .addr      (addr_v[p]),
            .din       (din_v[p]),
            .dinp      (dinp_v[p]),
            .own_row   (rd_v[p][p]),
            .other_row (rd_v[NPORT-1-p][p]),
            .row_o     (row_v[p]),
            .wr_o      (wr_v[p]),
            .store_o   (store_v[p]),
            .dout      (dout_v[p]),
            .doutp     (doutp_v[p])
        );
    end

    assign dout_a  = dout_v[0];
    assign doutp_a = doutp_v[0];
    assign dout_b  = dout_v[1];
    assign doutp_b = doutp_v[1];

endmodule

// File: tb/tb_twin_ratio_ram.sv
module tb_twin_ratio_ram;
    localparam int DB = 1024;
    localparam int AW = $clog2(DB);
    localparam int PB = DB / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          en_a, we_a, en_b, we_b;
    logic [2:0]    mode_a, mode_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [15:0]   din_a, din_b, dout_a, dout_b;
    logic [1:0]    dinp_a, dinp_b, doutp_a, doutp_b;

    twin_ratio_ram #(.DATA_BITS(DB)) dut (
        .rst_n(rst_n),
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .mode_a(mode_a), .addr_a(addr_a),
        .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .mode_b(mode_b), .addr_b(addr_b),
        .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
    );

    logic [DB-1:0] ref_d;
    logic [PB-1:0] ref_p;
    int n_checks = 0;
    int n_errs   = 0;

    function automatic int sft(input int m);
        case (m)
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int word_of(input int m, input int a);
        return a & ((DB >> sft(m)) - 1);
    endfunction

    function automatic logic [15:0] exp_d(input int m, input int a);
        logic [15:0] e = '0;
        int w = 1 << sft(m);
        int n = word_of(m, a);
        for (int k = 0; k < w; k++) e[k] = ref_d[n*w + k];
        return e;
    endfunction

    function automatic logic [1:0] exp_p(input int m, input int a);
        logic [1:0] e = '0;
        int n = word_of(m, a);
        if (sft(m) == 3) e[0] = ref_p[n];
        if (sft(m) == 4) begin
            e[0] = ref_p[2*n];
            e[1] = ref_p[2*n+1];
        end
        return e;
    endfunction

    task automatic model_wr(input int m, input int a, input logic [15:0] d, input logic [1:0] p);
        int w = 1 << sft(m);
        int n = word_of(m, a);
        for (int k = 0; k < w; k++) ref_d[n*w + k] = d[k];
        if (sft(m) == 3) ref_p[n] = p[0];
        if (sft(m) == 4) begin
            ref_p[2*n]   = p[0];
            ref_p[2*n+1] = p[1];
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic idle();
        en_a = 0; we_a = 0; en_b = 0; we_b = 0;
    endtask

    // One access on one port; checks both data and parity outputs afterwards.
    task automatic op(input int port, input bit en, input bit we, input int m, input int a,
                      input logic [15:0] d, input logic [1:0] p, input string tag);
        logic [17:0] prev, act, expv;
        @(negedge clk);
        idle();
        prev = (port == 0) ? {doutp_a, dout_a} : {doutp_b, dout_b};
        if (port == 0) begin
            en_a = en; we_a = we; mode_a = 3'(m); addr_a = AW'(a); din_a = d; dinp_a = p;
        end else begin
            en_b = en; we_b = we; mode_b = 3'(m); addr_b = AW'(a); din_b = d; dinp_b = p;
        end
        @(posedge clk);
        #1;
        if (en && we) model_wr(m, a, d, p);
        expv = en ? {exp_p(m, a), exp_d(m, a)} : prev;
        act  = (port == 0) ? {doutp_a, dout_a} : {doutp_b, dout_b};
        chk(act == expv, tag, act, expv);
    endtask

    initial begin
        #(8 * 190000);
        n_errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        ref_d = '0; ref_p = '0;
        idle();
        mode_a = 0; mode_b = 0; addr_a = '0; addr_b = '0;
        din_a = '0; din_b = '0; dinp_a = '0; dinp_b = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({doutp_a, dout_a, doutp_b, dout_b} == '0, "R10 reset outputs",
            {doutp_a, dout_a}, 18'h0);
        @(negedge clk);
        rst_n = 1;

        // R6 R1: fill the whole store through port A in the widest shape
        for (int i = 0; i < DB/16; i++)
            op(0, 1, 1, 4, i, 16'(i * 16'h3B1D) ^ 16'hA5C3, 2'(i) ^ 2'b10, "R6 fill write-first");

        // R3 R7 R8: read the whole space back through port B in every shape
        for (int m = 0; m < 5; m++)
            for (int a = 0; a < (DB >> sft(m)); a++)
                op(1, 1, 0, m, a, '0, '0, "R3 R7 R8 narrow readback");

        // R2: codes 5..7 read like the 1-bit shape
        for (int m = 5; m < 8; m++)
            for (int a = 0; a < 40; a++)
                op(0, 1, 0, m, a * 7, '0, '0, "R2 unused mode code");

        // R3: upper address bits are ignored
        for (int a = 0; a < DB/16; a++)
            op(0, 1, 0, 4, a | (1 << (AW-1)) | (1 << (AW-2)), '0, '0, "R3 upper address bits");
        for (int a = 0; a < 64; a++)
            op(1, 1, 0, 3, a | (1 << (AW-1)), '0, '0, "R3 upper bits in 9-bit shape");

        // R4 R6 R8: narrow writes through port B, wide readback through port A
        for (int m = 0; m < 5; m++) begin
            for (int j = 0; j < 24; j++) begin
                int a = (j * 37 + m * 11) % (DB >> sft(m));
                op(1, 1, 1, m, a, 16'(j * 16'h1F35 + m), 2'(j + m), "R4 R6 narrow write");
            end
            for (int r = 0; r < DB/16; r++)
                op(0, 1, 0, 4, r, '0, '0, "R4 R8 wide readback");
            for (int r = 0; r < DB/8; r++)
                op(0, 1, 0, 3, r, '0, '0, "R4 9-bit parity readback");
        end

        // R5: disabled port holds its outputs and writes nothing
        op(0, 1, 0, 4, 9, '0, '0, "R5 read before hold");
        op(0, 0, 0, 4, 20, '0, '0, "R5 hold while disabled");
        op(0, 0, 1, 4, 9, 16'hDEAD, 2'b11, "R5 disabled write held");
        op(0, 1, 0, 4, 9, '0, '0, "R5 disabled write ignored");

        // R9: both ports write at once, different rows, then same row disjoint bits
        for (int t = 0; t < 2; t++) begin
            int aa = (t == 0) ? 3 : 20;
            int ma = (t == 0) ? 4 : 2;
            int ab = (t == 0) ? 10 * 4 + 1 : 21;
            @(negedge clk);
            idle();
            en_a = 1; we_a = 1; mode_a = 3'(ma); addr_a = AW'(aa); din_a = 16'h5A0F; dinp_a = 2'b01;
            en_b = 1; we_b = 1; mode_b = 3'd2;   addr_b = AW'(ab); din_b = 16'h0009; dinp_b = 2'b00;
            @(posedge clk);
            #1;
            model_wr(ma, aa, 16'h5A0F, 2'b01);
            model_wr(2, ab, 16'h0009, 2'b00);
            chk({doutp_a, dout_a} == {exp_p(ma, aa), exp_d(ma, aa)}, "R9 port A concurrent write",
                {doutp_a, dout_a}, {exp_p(ma, aa), exp_d(ma, aa)});
            chk({doutp_b, dout_b} == {exp_p(2, ab), exp_d(2, ab)}, "R9 port B concurrent write",
                {doutp_b, dout_b}, {exp_p(2, ab), exp_d(2, ab)});
            for (int r = 0; r < 12; r++)
                op(1, 1, 0, 4, r, '0, '0, "R9 concurrent readback");
        end

        // R10 R1: reset clears outputs, keeps stored contents
        @(negedge clk);
        idle();
        rst_n = 0;
        #1;
        chk({doutp_a, dout_a, doutp_b, dout_b} == '0, "R10 reset mid-run",
            {doutp_b, dout_b}, 18'h0);
        @(negedge clk);
        rst_n = 1;
        for (int r = 0; r < DB/16; r++)
            op(1, 1, 0, 4, r, '0, '0, "R1 contents kept over reset");

        @(negedge clk);
        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule